// File: doc/BRIEF.md
# Shared Loop-Buffer Wavelength Allocator

This controller manages a set of shared buffer modules in a packet switch that works in fixed slots. Each module holds packets on a fixed number of wavelengths inside a recirculating loop. Each module is reached through a group of D request lanes. When a packet loses output contention, its lane asks the controller for buffering. The lane's module is fixed by the lane index. Within that slot the controller either gives the lane a free wavelength or tells it to drop the packet.

For every buffered packet, the controller keeps a handle (module, wavelength) in a first-in first-out queue that belongs to the packet's output. In any slot where that output is not taking a directly switched packet, the controller issues a read for the oldest handle. The wavelength of that handle then returns to the free pool.

A parameter selects between two fabric port mappings. In the feed-forward mapping, buffer lanes sit after the direct paths of the scheduling stage. In the feedback mapping, they occupy the upper half of a doubled fabric.

Top module: `loopbuf_alloc`

## Requirements
- R1: After reset every wavelength of every module is free and every output queue is empty, so no read is issued until a packet has been granted.
- R2: A requesting lane receives the lowest-numbered wavelength that is free in its module at the start of the slot. Lanes of one module are served in increasing lane order, each taking the next free wavelength.
- R3: A requesting lane whose module has no wavelength left in that slot is dropped. Each lane gets either a grant or a drop in the same slot it asks, and a lane that does not request gets neither.
- R4: A granted wavelength stays reserved and is not granted again until its packet has been read.
- R5: A read returns its wavelength to the pool, and that wavelength can be granted from the next slot on.
- R6: Reads for one output follow grant order. Among grants to the same output in one slot, the lower lane goes first.
- R7: Each output issues at most one read per slot, and only when its queue holds a handle granted in an earlier slot. The read carries that handle's module (rd_mod) and wavelength (rd_wl).
- R8: No read is issued for an output while direct_busy is high for it. The handle stays at the head of the queue.
- R9: Lane i belongs to module i/D, there are N/D modules, and at most N/D·B packets are buffered at any time.
- R10: buf_port for lane i is DIRECT+i in the feed-forward mapping and N+i in the feedback mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_req | input | N | Lane i asks to buffer a packet |
| buf_dst | input | N·OW | Output of lane i's packet, OW bits per lane |
| direct_busy | input | N | Output o takes a directly switched packet this slot |
| buf_grant | output | N | Lane i was given a wavelength |
| buf_drop | output | N | Lane i's packet is dropped |
| buf_wl | output | N·WLW | Wavelength granted to lane i |
| buf_port | output | N·PRW | Fabric port of lane i's buffer path |
| rd_valid | output | N | Read issued for output o |
| rd_mod | output | N·MW | Module of the read for output o |
| rd_wl | output | N·WLW | Wavelength of the read for output o |

## Verification
The assertions assume that the requests arrive only through buf_req and that each buf_dst value names an existing output. They also assume that direct_busy says nothing about buffer state, so any busy pattern is legal. The stimulus draws destinations only within 0..N-1 and runs several phases: heavy load that fills the modules and forces drops, light load with few busy outputs, and all outputs held busy so that queues back up. Drain phases with no busy outputs let every queue empty, so release and reuse of wavelengths are exercised repeatedly.

// File: rtl/loopbuf_pkg.sv
package loopbuf_pkg;
   typedef enum logic {
      LB_FEEDFWD  = 1'b0,
      LB_FEEDBACK = 1'b1
   } lb_mode_e;

   function automatic int lb_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/lb_wl_picker.sv
module lb_wl_picker #(
   parameter int B   = 4,
   parameter int D   = 4,
   parameter int WLW = 2
) (
   input  logic [B-1:0]     free_mask,
   input  logic [D-1:0]     req,
   output logic [D-1:0]     gnt,
   output logic [D*WLW-1:0] wl,
   output logic [B-1:0]     take
);
   logic [B-1:0]   avail;
   logic           found;
   logic [WLW-1:0] idx;

   always_comb begin
      avail = free_mask;
      gnt   = '0;
      wl    = '0;
      found = 1'b0;
      idx   = '0;
      for (int l = 0; l < D; l++) begin
         found = 1'b0;
         idx   = '0;
         for (int w = B - 1; w >= 0; w--) begin
            if (avail[w]) begin
               found = 1'b1;
               idx   = WLW'(w);
            end
         end
         if (req[l] && found) begin
            gnt[l]            = 1'b1;
            wl[l*WLW +: WLW]  = idx;
            avail[idx]        = 1'b0;
         end
      end
      take = free_mask & ~avail;
   end
endmodule

// File: rtl/lb_handle_fifo.sv
module lb_handle_fifo #(
   parameter int LANES = 8,
   parameter int HW    = 3,
   parameter int PTRW  = 3,
   parameter int RW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  push,
   input  logic [LANES*RW-1:0] push_rank,
   input  logic [LANES*HW-1:0] push_data,
   input  logic              pop,
   output logic [HW-1:0]     head,
   output logic              not_empty
);
   localparam int DEPTH = 1 << PTRW;
   localparam int CW    = $clog2(DEPTH + 1);

   logic [HW-1:0]   mem [DEPTH];
   logic [PTRW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0]   cnt;
   logic [CW-1:0]   npush;

   always_comb npush = CW'($countones(push));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         for (int l = 0; l < LANES; l++) begin
            if (push[l])
               mem[wr_ptr + PTRW'(push_rank[l*RW +: RW])] <= push_data[l*HW +: HW];
         end
         wr_ptr <= wr_ptr + PTRW'(npush);
         if (pop) rd_ptr <= rd_ptr + 1'b1;
         cnt <= cnt + npush - CW'(pop);
      end
   end

   assign head      = mem[rd_ptr];
   assign not_empty = (cnt != '0);
endmodule

// File: rtl/loopbuf_alloc.sv
module loopbuf_alloc
   import loopbuf_pkg::*;
#(
   parameter int       N      = 8,
   parameter int       D      = 4,
   parameter int       B      = 4,
   parameter int       DIRECT = 8,
   parameter lb_mode_e MODE   = LB_FEEDFWD,
   localparam int MODS = N / D,
   localparam int OW   = lb_w(N),
   localparam int WLW  = lb_w(B),
   localparam int MW   = lb_w(MODS),
   localparam int FAB  = (MODE == LB_FEEDBACK) ? 2 * N : DIRECT + N,
   localparam int PRW  = lb_w(FAB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      buf_req,
   input  logic [N*OW-1:0]   buf_dst,
   input  logic [N-1:0]      direct_busy,
   output logic [N-1:0]      buf_grant,
   output logic [N-1:0]      buf_drop,
   output logic [N*WLW-1:0]  buf_wl,
   output logic [N*PRW-1:0]  buf_port,
   output logic [N-1:0]      rd_valid,
   output logic [N*MW-1:0]   rd_mod,
   output logic [N*WLW-1:0]  rd_wl
);
   localparam int CAP  = MODS * B;
   localparam int PTRW = lb_w(CAP);
   localparam int RW   = lb_w(N);
   localparam int HW   = MW + WLW;

   if (N % D != 0) begin : g_bad_group
      $error("loopbuf_alloc: N must be a multiple of D");
   end
   if (B < 1 || D < 1 || N < 2) begin : g_bad_size
      $error("loopbuf_alloc: B, D must be >= 1 and N >= 2");
   end

   logic [N*RW-1:0] rank;
   logic [N*HW-1:0] handle;
   logic [MW-1:0]   head_mod [N];
   logic [WLW-1:0]  head_wl  [N];

   // Fabric port mapping chosen by variant (R10)
   for (genvar i = 0; i < N; i++) begin : g_port
      if (MODE == LB_FEEDBACK) begin : g_fb
         assign buf_port[i*PRW +: PRW] = PRW'(N + i);
      end else begin : g_ff
         assign buf_port[i*PRW +: PRW] = PRW'(DIRECT + i);
      end
   end

   // Per-module free masks and wavelength pickers (R2..R5, R9)
   for (genvar m = 0; m < MODS; m++) begin : g_mod
      logic [B-1:0] free_q;
      logic [B-1:0] take;
      logic [B-1:0] rel;

      lb_wl_picker #(.B(B), .D(D), .WLW(WLW)) u_pick (
         .free_mask (free_q),
         .req       (buf_req[m*D +: D]),
         .gnt       (buf_grant[m*D +: D]),
         .wl        (buf_wl[m*D*WLW +: D*WLW]),
         .take      (take)
      );

      always_comb begin
         rel = '0;
         for (int o = 0; o < N; o++) begin
            if (rd_valid[o] && head_mod[o] == MW'(m))
               rel[head_wl[o]] = 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) free_q <= '1;
         else        free_q <= (free_q & ~take) | rel;
      end
   end

   assign buf_drop = buf_req & ~buf_grant;

   // Handles and same-slot ordering ranks (R6)
   always_comb begin
      rank   = '0;
      handle = '0;
      for (int l = 0; l < N; l++) begin
         handle[l*HW +: HW] = {MW'(l / D), buf_wl[l*WLW +: WLW]};
         for (int j = 0; j < l; j++) begin
            if (buf_grant[j] && buf_dst[j*OW +: OW] == buf_dst[l*OW +: OW])
               rank[l*RW +: RW] = rank[l*RW +: RW] + 1'b1;
         end
      end
   end

   // Per-output queues and read issue (R6..R8)
   for (genvar o = 0; o < N; o++) begin : g_out
      logic [N-1:0]  push;
      logic [HW-1:0] head;
      logic          ne;

      always_comb begin
         for (int l = 0; l < N; l++)
            push[l] = buf_grant[l] && (buf_dst[l*OW +: OW] == OW'(o));
      end

      lb_handle_fifo #(.LANES(N), .HW(HW), .PTRW(PTRW), .RW(RW)) u_q (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (push),
         .push_rank (rank),
         .push_data (handle),
         .pop       (rd_valid[o]),
         .head      (head),
         .not_empty (ne)
      );

      assign head_mod[o] = head[HW-1 -: MW];
      assign head_wl[o]  = head[WLW-1:0];
      assign rd_valid[o] = ne && !direct_busy[o];
      assign rd_mod[o*MW +: MW]   = head_mod[o];
      assign rd_wl[o*WLW +: WLW]  = head_wl[o];
   end
endmodule

// File: rtl/loopbuf_alloc_chk.sv
module loopbuf_alloc_chk
   import loopbuf_pkg::*;
#(
   parameter int N   = 8,
   parameter int D   = 4,
   parameter int B   = 4,
   parameter int WLW = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N-1:0]     buf_req,
   input logic [N-1:0]     direct_busy,
   input logic [N-1:0]     buf_grant,
   input logic [N-1:0]     buf_drop,
   input logic [N*WLW-1:0] buf_wl,
   input logic [N-1:0]     rd_valid
);
   localparam int CAP = (N / D) * B;
   int occ;

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= 0;
      else        occ <= occ + $countones(buf_grant) - $countones(rd_valid);
   end

   a_r3_grant_xor_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_grant & buf_drop) == '0);
   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      ((buf_grant | buf_drop) & ~buf_req) == '0);
   a_r8_direct_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid & direct_busy) == '0);
   a_r9_capacity: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CAP);
   a_r7_read_backed: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_valid) <= occ);

   for (genvar m = 0; m < N / D; m++) begin : g_m
      for (genvar a = 0; a < D; a++) begin : g_a
         for (genvar b = a + 1; b < D; b++) begin : g_b
            a_r2_distinct_wl: assert property (@(posedge clk) disable iff (!rst_n)
               (buf_grant[m*D+a] && buf_grant[m*D+b]) |->
               (buf_wl[(m*D+a)*WLW +: WLW] != buf_wl[(m*D+b)*WLW +: WLW]));
         end
      end
   end
endmodule

bind loopbuf_alloc loopbuf_alloc_chk #(.N(N), .D(D), .B(B), .WLW(WLW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .buf_req     (buf_req),
   .direct_busy (direct_busy),
   .buf_grant   (buf_grant),
   .buf_drop    (buf_drop),
   .buf_wl      (buf_wl),
   .rd_valid    (rd_valid)
);

// File: tb/loopbuf_alloc_bench.sv
module loopbuf_alloc_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8, D = 4, B = 4, DIRECT = 8;
   localparam int MODS = N / D;
   localparam int OW = 3, WLW = 2, MW = 1, PRW = 4;

   logic clk = 0, rst_n = 0;
   logic [N-1:0]     buf_req = '0, direct_busy = '0;
   logic [N*OW-1:0]  buf_dst = '0;
   logic [N-1:0]     buf_grant, buf_drop, rd_valid;
   logic [N*WLW-1:0] buf_wl, rd_wl;
   logic [N*PRW-1:0] buf_port;
   logic [N*MW-1:0]  rd_mod;

   int errors = 0, checks = 0;
   bit free_m [MODS][B];
   int q [N][$];

   always #(CLK_PERIOD/2) clk = ~clk;

   loopbuf_alloc #(.N(N), .D(D), .B(B), .DIRECT(DIRECT)) u_loopbuf_alloc (
      .clk(clk), .rst_n(rst_n), .buf_req(buf_req), .buf_dst(buf_dst),
      .direct_busy(direct_busy), .buf_grant(buf_grant), .buf_drop(buf_drop),
      .buf_wl(buf_wl), .buf_port(buf_port), .rd_valid(rd_valid),
      .rd_mod(rd_mod), .rd_wl(rd_wl));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // One slot: drive at negedge, compare, then advance the model
   task automatic slot(input int req_pct, input int busy_pct);
      bit tmp [MODS][B];
      int eg [N];
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         buf_req[i]              = ($urandom % 100) < req_pct;
         buf_dst[i*OW +: OW]     = OW'($urandom % N);
         direct_busy[i]          = ($urandom % 100) < busy_pct;
      end
      #1;
      tmp = free_m;
      // R2 R3 R4 R9: lane i -> module i/D, lowest free wavelength, else drop
      for (int i = 0; i < N; i++) begin
         int m = i / D;
         int w = -1;
         eg[i] = -1;
         if (buf_req[i]) begin
            for (int k = 0; k < B; k++) if (w < 0 && tmp[m][k]) w = k;
            if (w >= 0) begin tmp[m][w] = 0; eg[i] = w; end
         end
         chk(buf_grant[i] == (eg[i] >= 0), "R3 R4 grant", buf_grant[i], eg[i] >= 0);
         chk(buf_drop[i] == (buf_req[i] && eg[i] < 0), "R3 drop", buf_drop[i],
             buf_req[i] && eg[i] < 0);
         if (eg[i] >= 0)
            chk(buf_wl[i*WLW +: WLW] == eg[i], "R2 R9 wavelength",
                buf_wl[i*WLW +: WLW], eg[i]);
      end
      // R6 R7 R8: one read per free output, oldest handle first
      for (int o = 0; o < N; o++) begin
         bit ev = (q[o].size() > 0) && !direct_busy[o];
         chk(rd_valid[o] == ev, direct_busy[o] ? "R8 read blocked" : "R7 read issue",
             rd_valid[o], ev);
         if (ev) begin
            int h = q[o][0];
            chk(rd_mod[o*MW +: MW] * B + rd_wl[o*WLW +: WLW] == h, "R6 read order",
                rd_mod[o*MW +: MW] * B + rd_wl[o*WLW +: WLW], h);
         end
      end
      // model update; R5: released wavelengths free from the next slot
      for (int o = 0; o < N; o++) begin
         if ((q[o].size() > 0) && !direct_busy[o]) begin
            int h = q[o].pop_front();
            tmp[h / B][h % B] = 1;
         end
      end
      for (int i = 0; i < N; i++)
         if (eg[i] >= 0) q[buf_dst[i*OW +: OW]].push_back((i / D) * B + eg[i]);
      free_m = tmp;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(7));
      for (int m = 0; m < MODS; m++) for (int k = 0; k < B; k++) free_m[m][k] = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      // R1: queues empty after reset
      chk(rd_valid == '0, "R1 no read after reset", rd_valid, 0);
      // R10: feed-forward port mapping
      for (int i = 0; i < N; i++)
         chk(buf_port[i*PRW +: PRW] == DIRECT + i, "R10 port map",
             buf_port[i*PRW +: PRW], DIRECT + i);
      repeat (300) slot(75, 50);
      repeat (100) slot(25, 25);
      repeat (20)  slot(0, 0);
      repeat (40)  slot(100, 100);
      repeat (20)  slot(0, 0);
      repeat (200) slot(50, 10);
      repeat (30)  slot(0, 0);
      @(negedge clk);
      buf_req = '0;
      #1;
      chk(rd_valid == '0, "R5 R7 drained", rd_valid, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule